// File: doc/BRIEF.md
# Variable-Length Instruction Fetch Unit

The unit takes a program counter and pulls one instruction of 1, 2, 5 or 6 bytes from a byte-addressed instruction memory. The memory answers through a single read port that returns a window of consecutive bytes starting at the requested address. Each byte of the window carries its own success flag, so a window that runs past the end of the memory reports only the bytes that could not be read. The opcode in the first byte decides how long the instruction is. It decides whether a register-specifier byte follows and whether a 4-byte constant follows. The unit splits these bytes into their fields, computes the sequential next PC, and classifies the fetch with a 2-bit status.

A request is given by raising `fetch_req` with `fetch_pc` for one cycle. The memory window must respond in the same cycle. On the next clock edge the unit registers the decoded fields and raises `out_valid` for one cycle. When no request is made, the registered fields keep their values. Status encoding: 0 = ok, 1 = halt, 2 = address error, 3 = invalid instruction. The register code 15 means "no register".

Top module: `vlf_fetch`

## Requirements
- R1: The first byte gives `icode` in bits 7:4 and `ifun` in bits 3:0.
- R2: If the first byte fails to read, the result is `icode`=1 (no-op) and `ifun`=0, with `ra`=`rb`=15, `valc`=0, `valp`=PC+1 and status 2. Any other byte is then ignored.
- R3: `valp` equals PC+1, plus 1 when a register byte is needed, plus 4 when a constant is needed. A register byte is needed for opcodes 2, 3, 4, 5, 6, 10 and 11. A constant is needed for opcodes 3, 4, 5, 7 and 8.
- R4: When a register byte is needed and reads correctly, `ra` is bits 7:4 and `rb` is bits 3:0 of the byte at PC+1. Otherwise both are 15.
- R5: A needed constant is assembled little-endian from four bytes starting at PC+2 when a register byte precedes it and at PC+1 otherwise. Without a needed constant, `valc` is 0.
- R6: Opcodes 12 to 15 read correctly give status 3 with `ra`=`rb`=15, `valc`=0 and `valp`=PC+1.
- R7: Opcode 0 (halt) read without a fault gives status 1.
- R8: A failed read of a needed register byte gives status 2 and forces `ra`/`rb` to 15. A failed read of any needed constant byte gives status 2 and forces `valc` to 0. The other fields keep their decoded values.
- R9: Address error takes priority over invalid-instruction and halt status.
- R10: Read failures in bytes that the opcode does not need have no effect on any output.
- R11: `out_valid` rises exactly one cycle after `fetch_req`. Without a request, all decoded outputs hold their values.
- R12: After reset, `out_valid` is 0, status is 0, `icode` is 1, `ra`/`rb` are 15, and `valc` and `valp` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fetch_req | input | 1 | Fetch request for this cycle |
| fetch_pc | input | 32 | Address of the instruction to fetch |
| mem_addr | output | 32 | Start address of the memory read window |
| mem_rdata | input | 48 | Byte window; byte k at bits 8k+7:8k is the byte at mem_addr+k |
| mem_ok | input | 6 | Per-byte read success flags for the window |
| out_valid | output | 1 | Registered fields belong to a fetch completed this cycle |
| icode | output | 4 | Instruction code |
| ifun | output | 4 | Function code |
| ra | output | 4 | First register specifier |
| rb | output | 4 | Second register specifier |
| valc | output | 32 | Constant word |
| valp | output | 32 | Fall-through PC |
| stat | output | 2 | Fetch status |

## Verification
Every output is registered one stage after the request, so a wrong length class, offset selection or fault merge appears on the first `out_valid` cycle after the bad fetch. It shows as a `valp` off by 1 or 4, a constant shifted by one byte, or a status that is wrong or swapped. The directed fetches place instructions against the end of the bench memory. This lets a fault land on each byte position in turn: first byte, register byte, a constant byte, and a byte that is not needed. A wrong priority or a fault applied to the wrong field is then visible in that same cycle. The hold case catches a missing clock enable as output drift during idle cycles.

// File: rtl/vlf_pkg.sv
package vlf_pkg;
  localparam int unsigned OPW = 4;
  localparam logic [OPW-1:0] OP_HALT = 4'd0;
  localparam logic [OPW-1:0] OP_NOP  = 4'd1;
  localparam logic [OPW-1:0] REG_NONE = 4'hF;
  localparam int unsigned NUM_VALID_OPS = 12;
  // one bit per opcode value
  localparam logic [15:0] NEEDS_REG_MASK   = 16'h0C7C;
  localparam logic [15:0] NEEDS_CONST_MASK = 16'h01B8;

  typedef enum logic [1:0] {
    ST_OK  = 2'd0,
    ST_HLT = 2'd1,
    ST_ADR = 2'd2,
    ST_INS = 2'd3
  } fetch_stat_e;
endpackage

// File: rtl/vlf_opclass.sv
module vlf_opclass
  import vlf_pkg::*;
#(
  parameter int unsigned NUM_VALID = NUM_VALID_OPS
) (
  input  logic [OPW-1:0] op,
  output logic           need_reg,
  output logic           need_const,
  output logic           op_valid
);
  always_comb begin
    need_reg   = NEEDS_REG_MASK[op];
    need_const = NEEDS_CONST_MASK[op];
    op_valid   = (32'(op) < NUM_VALID);
  end
endmodule

// File: rtl/vlf_const_gather.sv
module vlf_const_gather #(
  parameter int unsigned WORD_BYTES = 4,
  localparam int unsigned WIN_BYTES = WORD_BYTES + 2,
  localparam int unsigned WORD_W = 8 * WORD_BYTES
) (
  input  logic [8*WIN_BYTES-1:0] win_data,
  input  logic [WIN_BYTES-1:0]   win_ok,
  input  logic                   after_reg,
  output logic [WORD_W-1:0]      word,
  output logic                   word_ok
);
  logic [WORD_BYTES-1:0] byte_ok;

  // byte 0 of the window is the opcode; it is not part of the constant
  logic unused_op_bits;
  assign unused_op_bits = ^{win_data[7:0], win_ok[0]};

  for (genvar k = 0; k < WORD_BYTES; k++) begin : g_byte
    localparam int unsigned LO = 1 + k;
    localparam int unsigned HI = 2 + k;
    assign word[8*k +: 8] = after_reg ? win_data[8*HI +: 8] : win_data[8*LO +: 8];
    assign byte_ok[k]     = after_reg ? win_ok[HI] : win_ok[LO];
  end

  assign word_ok = &byte_ok;
endmodule

// File: rtl/vlf_fetch.sv
module vlf_fetch
  import vlf_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned WORD_BYTES = 4,
  localparam int unsigned WIN_BYTES = WORD_BYTES + 2,
  localparam int unsigned WORD_W = 8 * WORD_BYTES
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   fetch_req,
  input  logic [ADDR_W-1:0]      fetch_pc,
  output logic [ADDR_W-1:0]      mem_addr,
  input  logic [8*WIN_BYTES-1:0] mem_rdata,
  input  logic [WIN_BYTES-1:0]   mem_ok,
  output logic                   out_valid,
  output logic [OPW-1:0]         icode,
  output logic [OPW-1:0]         ifun,
  output logic [OPW-1:0]         ra,
  output logic [OPW-1:0]         rb,
  output logic [WORD_W-1:0]      valc,
  output logic [ADDR_W-1:0]      valp,
  output logic [1:0]             stat
);
  logic [OPW-1:0]    n_icode, n_ifun, n_ra, n_rb;
  logic [WORD_W-1:0] n_valc;
  logic [ADDR_W-1:0] n_valp;
  fetch_stat_e       n_stat;

  logic need_reg, need_const, op_valid;
  logic [WORD_W-1:0] c_word;
  logic c_ok;
  logic head_ok, reg_fault, const_fault;

  assign mem_addr = fetch_pc;
  assign head_ok  = mem_ok[0];

  always_comb begin
    n_icode = head_ok ? mem_rdata[7:4] : OP_NOP;
    n_ifun  = head_ok ? mem_rdata[3:0] : '0;
  end

  vlf_opclass #(.NUM_VALID(NUM_VALID_OPS)) u_opclass (
    .op         (n_icode),
    .need_reg   (need_reg),
    .need_const (need_const),
    .op_valid   (op_valid)
  );

  vlf_const_gather #(.WORD_BYTES(WORD_BYTES)) u_const (
    .win_data  (mem_rdata),
    .win_ok    (mem_ok),
    .after_reg (need_reg),
    .word      (c_word),
    .word_ok   (c_ok)
  );

  always_comb begin
    reg_fault   = need_reg & ~mem_ok[1];
    const_fault = need_const & ~c_ok;
    if (need_reg && mem_ok[1]) begin
      n_ra = mem_rdata[15:12];
      n_rb = mem_rdata[11:8];
    end else begin
      n_ra = REG_NONE;
      n_rb = REG_NONE;
    end
    n_valc = (need_const && c_ok) ? c_word : '0;
    n_valp = fetch_pc + ADDR_W'(1) + ADDR_W'(need_reg)
           + (need_const ? ADDR_W'(WORD_BYTES) : '0);
    if (!head_ok || reg_fault || const_fault) n_stat = ST_ADR;
    else if (!op_valid)                       n_stat = ST_INS;
    else if (n_icode == OP_HALT)              n_stat = ST_HLT;
    else                                      n_stat = ST_OK;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      icode     <= OP_NOP;
      ifun      <= '0;
      ra        <= REG_NONE;
      rb        <= REG_NONE;
      valc      <= '0;
      valp      <= '0;
      stat      <= ST_OK;
    end else begin
      out_valid <= fetch_req;
      if (fetch_req) begin
        icode <= n_icode;
        ifun  <= n_ifun;
        ra    <= n_ra;
        rb    <= n_rb;
        valc  <= n_valc;
        valp  <= n_valp;
        stat  <= n_stat;
      end
    end
  end
endmodule

// File: rtl/vlf_fetch_chk.sv
module vlf_fetch_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        fetch_req,
  input logic [31:0] fetch_pc,
  input logic [5:0]  mem_ok,
  input logic        out_valid,
  input logic [3:0]  icode,
  input logic [3:0]  ifun,
  input logic [3:0]  ra,
  input logic [3:0]  rb,
  input logic [31:0] valc,
  input logic [31:0] valp,
  input logic [1:0]  stat
);
  logic [31:0] pc_q;
  logic        ok0_q;
  logic [31:0] len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q  <= '0;
      ok0_q <= 1'b1;
    end else if (fetch_req) begin
      pc_q  <= fetch_pc;
      ok0_q <= mem_ok[0];
    end
  end

  assign len = valp - pc_q;

  AST_LEN_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (len == 32'd1 || len == 32'd2 || len == 32'd5 || len == 32'd6)); // R3
  AST_HEAD_MISS_NOP: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !ok0_q) |-> (icode == 4'd1 && ifun == 4'd0 && stat == 2'd2)); // R2
  AST_NO_REGBYTE: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && (len == 32'd1 || len == 32'd5)) |-> (ra == 4'hF && rb == 4'hF)); // R4
  AST_SHORT_NO_CONST: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && len < 32'd5) |-> (valc == 32'd0)); // R5
  AST_HALT_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && stat == 2'd1) |-> (icode == 4'd0)); // R7
  AST_INVALID_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && stat == 2'd3) |-> (icode >= 4'd12 && len == 32'd1)); // R6
  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_req |=> out_valid); // R11
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> ($stable(valp) && $stable(valc) && $stable(stat) && $stable(ra)
                    && $stable(rb) && $stable(icode) && $stable(ifun))); // R11
endmodule

bind vlf_fetch vlf_fetch_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .fetch_req (fetch_req),
  .fetch_pc  (fetch_pc),
  .mem_ok    (mem_ok),
  .out_valid (out_valid),
  .icode     (icode),
  .ifun      (ifun),
  .ra        (ra),
  .rb        (rb),
  .valc      (valc),
  .valp      (valp),
  .stat      (stat)
);

// File: tb/vlf_fetch_tb.sv
module vlf_fetch_tb;
  logic        clk;
  logic        rst_n;
  logic        fetch_req;
  logic [31:0] fetch_pc;
  logic [31:0] mem_addr;
  logic [47:0] mem_rdata;
  logic [5:0]  mem_ok;
  logic        out_valid;
  logic [3:0]  icode, ifun, ra, rb;
  logic [31:0] valc, valp;
  logic [1:0]  stat;

  int n_checks = 0;
  int n_fail = 0;
  logic [7:0] mem [0:63];

  vlf_fetch u_dut (
    .clk(clk), .rst_n(rst_n), .fetch_req(fetch_req), .fetch_pc(fetch_pc),
    .mem_addr(mem_addr), .mem_rdata(mem_rdata), .mem_ok(mem_ok),
    .out_valid(out_valid), .icode(icode), .ifun(ifun), .ra(ra), .rb(rb),
    .valc(valc), .valp(valp), .stat(stat)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // behavioural memory: 64 bytes, anything at or above 64 fails to read
  always_comb begin
    for (int k = 0; k < 6; k++) begin
      logic [31:0] a;
      a = mem_addr + 32'(k);
      mem_ok[k] = (a < 32'd64);
      mem_rdata[8*k +: 8] = (a < 32'd64) ? mem[a[5:0]] : 8'h00;
    end
  end

  task automatic fetch(input logic [31:0] pc, input logic [3:0] ei, ef, era, erb,
                       input logic [31:0] evc, evp, input logic [1:0] est, input string tag);
    @(negedge clk);
    fetch_pc = pc;
    fetch_req = 1'b1;
    @(negedge clk);
    fetch_req = 1'b0;
    n_checks++;
    if (!out_valid || icode != ei || ifun != ef || ra != era || rb != erb ||
        valc != evc || valp != evp || stat != est) begin
      n_fail++;
      $display("FAIL %s pc=%0d: got v=%0b ic=%h if=%h ra=%h rb=%h c=%h p=%0d st=%0d exp v=1 ic=%h if=%h ra=%h rb=%h c=%h p=%0d st=%0d",
               tag, pc, out_valid, icode, ifun, ra, rb, valc, valp, stat,
               ei, ef, era, erb, evc, evp, est);
    end
  endtask

  task automatic t_reset;
    n_checks++;
    if (out_valid !== 1'b0 || stat !== 2'd0 || icode !== 4'd1 || ra !== 4'hF ||
        rb !== 4'hF || valc !== 32'd0 || valp !== 32'd0) begin
      n_fail++;
      $display("FAIL R12 reset: got v=%b st=%0d ic=%h ra=%h rb=%h c=%h p=%h exp v=0 st=0 ic=1 ra=f rb=f c=0 p=0",
               out_valid, stat, icode, ra, rb, valc, valp);
    end
  endtask

  task automatic t_sequential;
    fetch(0,  4'h0, 4'h0, 4'hF, 4'hF, 32'd0, 32'd1, 2'd1, "R7 R1 halt");
    fetch(1,  4'h1, 4'h0, 4'hF, 4'hF, 32'd0, 32'd2, 2'd0, "R3 nop");
    fetch(2,  4'h2, 4'h0, 4'h3, 4'h4, 32'd0, 32'd4, 2'd0, "R4 reg only");
    fetch(4,  4'h3, 4'h0, 4'hF, 4'h2, 32'h12345678, 32'd10, 2'd0, "R5 reg+const");
    fetch(10, 4'h7, 4'h3, 4'hF, 4'hF, 32'hAABBCCDD, 32'd15, 2'd0, "R5 const only");
    fetch(15, 4'hC, 4'h5, 4'hF, 4'hF, 32'd0, 32'd16, 2'd3, "R6 invalid");
    fetch(16, 4'hB, 4'h0, 4'h9, 4'hA, 32'd0, 32'd18, 2'd0, "R4 op11");
  endtask

  task automatic t_head_fault;
    fetch(64, 4'h1, 4'h0, 4'hF, 4'hF, 32'd0, 32'd65, 2'd2, "R2 head miss");
  endtask

  task automatic t_tail_faults;
    mem[63] = 8'h60;
    fetch(63, 4'h6, 4'h0, 4'hF, 4'hF, 32'd0, 32'd65, 2'd2, "R8 reg byte miss");
    mem[61] = 8'h80; mem[62] = 8'h11; mem[63] = 8'h22;
    fetch(61, 4'h8, 4'h0, 4'hF, 4'hF, 32'd0, 32'd66, 2'd2, "R8 const miss");
    mem[59] = 8'h50; mem[60] = 8'h7E; mem[61] = 8'h01; mem[62] = 8'h02; mem[63] = 8'h03;
    fetch(59, 4'h5, 4'h0, 4'h7, 4'hE, 32'd0, 32'd65, 2'd2, "R8 last const byte miss keeps regs");
    mem[63] = 8'hE1;
    fetch(63, 4'hE, 4'h1, 4'hF, 4'hF, 32'd0, 32'd64, 2'd3, "R9 R10 invalid at edge");
    mem[56] = 8'hE0; mem[57] = 8'h80; mem[58] = 8'h44; mem[59] = 8'h33; mem[60] = 8'h22;
    mem[61] = 8'h11;
    fetch(57, 4'h8, 4'h0, 4'hF, 4'hF, 32'h11223344, 32'd62, 2'd0, "R5 const fits exactly");
  endtask

  task automatic t_unneeded;
    mem[63] = 8'h10;
    fetch(63, 4'h1, 4'h0, 4'hF, 4'hF, 32'd0, 32'd64, 2'd0, "R10 nop ignores miss");
    mem[63] = 8'h00;
    fetch(63, 4'h0, 4'h0, 4'hF, 4'hF, 32'd0, 32'd64, 2'd1, "R10 R7 halt at edge");
    mem[62] = 8'h20; mem[63] = 8'h56;
    fetch(62, 4'h2, 4'h0, 4'h5, 4'h6, 32'd0, 32'd64, 2'd0, "R10 reg op at edge");
  endtask

  task automatic t_hold;
    fetch(16, 4'hB, 4'h0, 4'h9, 4'hA, 32'd0, 32'd18, 2'd0, "R11 before hold");
    @(negedge clk);
    fetch_pc = 32'd64;
    @(negedge clk);
    @(negedge clk);
    n_checks++;
    if (out_valid !== 1'b0 || icode != 4'hB || ra != 4'h9 || rb != 4'hA ||
        valp != 32'd18 || stat != 2'd0) begin
      n_fail++;
      $display("FAIL R11 hold: got v=%b ic=%h ra=%h rb=%h p=%0d st=%0d exp v=0 ic=b ra=9 rb=a p=18 st=0",
               out_valid, icode, ra, rb, valp, stat);
    end
  endtask

  initial begin
    #2_000_000;
    n_fail++;
    $display("FAIL watchdog: got timeout exp completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin
    for (int i = 0; i < 64; i++) mem[i] = 8'h10;
    mem[0] = 8'h00; mem[1] = 8'h10;
    mem[2] = 8'h20; mem[3] = 8'h34;
    mem[4] = 8'h30; mem[5] = 8'hF2; mem[6] = 8'h78; mem[7] = 8'h56; mem[8] = 8'h34; mem[9] = 8'h12;
    mem[10] = 8'h73; mem[11] = 8'hDD; mem[12] = 8'hCC; mem[13] = 8'hBB; mem[14] = 8'hAA;
    mem[15] = 8'hC5;
    mem[16] = 8'hB0; mem[17] = 8'h9A;
    rst_n = 1'b0;
    fetch_req = 1'b0;
    fetch_pc = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_sequential();
    t_head_fault();
    t_tail_faults();
    t_unneeded();
    t_hold();
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end
endmodule